// File: doc/BRIEF.md
# Banked Byte Data Memory

This block is the data store of a small 8-bit controller. Each access carries an 8-bit data address. A segment register sits inside the block, and the two together select one byte of a 16-bit physical space. The lower half of the 8-bit space (0x00–0x7F) moves with the segment register. The upper half (0x80–0xFF) stays fixed, and its top sixteen bytes hold a register window. That window also contains four pointer registers, one of which is the segment register.

One access port serves all traffic. On each cycle the caller presents an address, an operation code, write data and a bit selector. Read data, the selected bit and a zero flag come back combinationally. Writes, bit set and bit clear, and the register decrement all take effect on the next rising clock edge. A stack qualifier pins lower-half accesses to segment 0 whatever the segment register holds.

Top module: `banked_dmem`

## Requirements
- R1: Addresses 0x80–0xFF are never banked. 0xF0–0xFF always reach the sixteen register bytes whatever the segment value, and 0x80–0xEF are unmapped.
- R2: For address bit 7 = 0 the physical address is {seg, 1'b0, addr[6:0]}. In segment 0, offsets 0x00–0x6F hold RAM and offsets 0x70–0x7F are unmapped.
- R3: Segments 1 to EXT_SEGS each hold 128 bytes of storage of their own. Segments above EXT_SEGS are unmapped.
- R4: The pointer registers sit at 0xFC, 0xFD, 0xFE and the segment register at 0xFF, and all four can be read and written. A write to 0xFF changes the decoding of accesses from the next cycle on.
- R5: When `stack_acc` is 1, a lower-half access uses segment 0 whatever the segment register holds. Such an access never alters the segment register, and a stack-qualified write to 0xFF is dropped.
- R6: Reset loads 0xFD with 0x6F and loads 0xFC, 0xFE and 0xFF with 0x00. Reset leaves RAM contents untouched.
- R7: A read of unmapped space returns 0x00 with both flags 0, and a write to unmapped space changes nothing.
- R8: Operation code 2 sets and code 3 clears bit `bit_sel` of the addressed byte. The other bits of that byte stay as they were.
- R9: `bit_flag` always shows bit `bit_sel` of the addressed byte. Code 0 (read) modifies nothing.
- R10: Code 4 on a register-window byte stores the byte minus one, and `zero_flag` is 1 in the same cycle when that result is 0. Code 4 on any other location modifies nothing.
- R11: Code 1 writes `wdata`. Read data follows the address combinationally, and a write becomes visible on the rising edge that ends its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 8 | Data address |
| wdata | input | 8 | Write data for code 1 |
| op | input | 3 | 0 read, 1 write, 2 bit set, 3 bit clear, 4 decrement |
| stack_acc | input | 1 | Stack qualifier: lower half forced to segment 0 |
| bit_sel | input | 3 | Bit index for set, clear and test |
| rdata | output | 8 | Addressed byte, 0x00 when unmapped |
| bit_flag | output | 1 | Bit `bit_sel` of the addressed byte |
| zero_flag | output | 1 | Decrement result is zero |

## Verification
The bench builds the block with EXT_SEGS = 3. With that value, segments 1–3 can be checked for storage that stays apart from segment 0 and from each other. Segment 4, the first unmapped segment, and segment 255 are then only a few writes away. The small setting keeps the extension array short, so a long directed and pseudo-random run can cover the banked RAM, the register window and the segment edge in a few thousand cycles.

// File: rtl/banked_dmem_pkg.sv
`timescale 1ns/1ps
package banked_dmem_pkg;
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_SETB  = 3'd2,
    OP_CLRB  = 3'd3,
    OP_DEC   = 3'd4
  } mem_op_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_REG  = 2'd2
  } tgt_e;

  localparam int BYTE_W     = 8;
  localparam int WIN_REGS   = 16;
  localparam int PTR_FIRST  = 12;
  localparam int IDX_SP     = 13;
  localparam int IDX_SEG    = 15;
  localparam int BASE_BYTES = 112;
  localparam int SEG_BYTES  = 128;
  localparam logic [BYTE_W-1:0] SP_INIT = 8'h6F;
endpackage

// File: rtl/bd_addr_decode.sv
`timescale 1ns/1ps
module bd_addr_decode
  import banked_dmem_pkg::*;
#(
  parameter int EXT_SEGS = 7,
  parameter int RAM_AW   = 10
) (
  input  logic [BYTE_W-1:0] addr,
  input  logic [BYTE_W-1:0] seg,
  input  logic              stk,
  output tgt_e              tgt,
  output logic [RAM_AW-1:0] ram_idx,
  output logic [3:0]        reg_idx
);
  logic [BYTE_W-1:0] eff_seg;

  always_comb begin
    eff_seg = stk ? '0 : seg;
    tgt     = TGT_NONE;
    ram_idx = '0;
    reg_idx = addr[3:0];
    if (addr[7]) begin
      if (addr[6:4] == 3'b111) tgt = TGT_REG;
    end else if (eff_seg == '0) begin
      if (addr[6:0] < 7'h70) begin
        tgt     = TGT_RAM;
        ram_idx = RAM_AW'(addr[6:0]);
      end
    end else if (int'(eff_seg) <= EXT_SEGS) begin
      tgt     = TGT_RAM;
      ram_idx = RAM_AW'(BASE_BYTES + (int'(eff_seg) - 1) * SEG_BYTES + int'(addr[6:0]));
    end
  end
endmodule

// File: rtl/bd_reg_window.sv
`timescale 1ns/1ps
module bd_reg_window
  import banked_dmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              stk,
  input  logic [3:0]        idx,
  input  logic [BYTE_W-1:0] wd,
  output logic [BYTE_W-1:0] rd,
  output logic [BYTE_W-1:0] seg
);
  logic [WIN_REGS-1:0][BYTE_W-1:0] regs;
  logic [WIN_REGS-1:0]             wen;

  for (genvar g = 0; g < WIN_REGS; g++) begin : g_reg
    logic [BYTE_W-1:0] q;
    assign wen[g] = we && (idx == 4'(g)) && !(stk && (g == IDX_SEG));
    if (g >= PTR_FIRST) begin : g_ptr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= (g == IDX_SP) ? SP_INIT : '0;
        else if (wen[g]) q <= wd;
      end
    end else begin : g_gen
      always_ff @(posedge clk) begin
        if (wen[g]) q <= wd;
      end
    end
    assign regs[g] = q;
  end

  assign rd  = regs[idx];
  assign seg = regs[IDX_SEG];

  p_stack_keeps_seg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stk |=> $stable(regs[IDX_SEG]));
  p_sp_reset_r6: assert property (@(posedge clk)
    $rose(rst_n) |-> (regs[IDX_SP] == SP_INIT && regs[IDX_SEG] == '0));
endmodule

// File: rtl/bd_ram_store.sv
`timescale 1ns/1ps
module bd_ram_store
  import banked_dmem_pkg::*;
#(
  parameter int DEPTH = 1008,
  parameter int AW    = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     idx,
  input  logic [BYTE_W-1:0] wd,
  output logic [BYTE_W-1:0] rd
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wd;
  end

  assign rd = mem[idx];
endmodule

// File: rtl/banked_dmem.sv
`timescale 1ns/1ps
module banked_dmem
  import banked_dmem_pkg::*;
#(
  parameter int EXT_SEGS = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic [2:0] op,
  input  logic       stack_acc,
  input  logic [2:0] bit_sel,
  output logic [7:0] rdata,
  output logic       bit_flag,
  output logic       zero_flag
);
  localparam int RAM_DEPTH = BASE_BYTES + EXT_SEGS * SEG_BYTES;
  localparam int RAM_AW    = $clog2(RAM_DEPTH);

  logic [1:0]        rst_sync;
  logic              core_rst_n;
  tgt_e              tgt;
  logic [RAM_AW-1:0] ram_idx;
  logic [3:0]        reg_idx;
  logic [BYTE_W-1:0] seg, ram_rd, reg_rd, rd_byte, wr_byte, mask;
  logic              do_wr, ram_we, reg_we;
  mem_op_e           op_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  bd_addr_decode #(.EXT_SEGS(EXT_SEGS), .RAM_AW(RAM_AW)) i_dec (
    .addr(addr), .seg(seg), .stk(stack_acc),
    .tgt(tgt), .ram_idx(ram_idx), .reg_idx(reg_idx)
  );

  bd_reg_window i_regs (
    .clk(clk), .rst_n(core_rst_n), .we(reg_we), .stk(stack_acc),
    .idx(reg_idx), .wd(wr_byte), .rd(reg_rd), .seg(seg)
  );

  bd_ram_store #(.DEPTH(RAM_DEPTH), .AW(RAM_AW)) i_ram (
    .clk(clk), .we(ram_we), .idx(ram_idx), .wd(wr_byte), .rd(ram_rd)
  );

  always_comb begin
    op_e = mem_op_e'(op);
    mask = BYTE_W'(1) << bit_sel;
    case (tgt)
      TGT_RAM: rd_byte = ram_rd;
      TGT_REG: rd_byte = reg_rd;
      default: rd_byte = '0;
    endcase
    wr_byte = rd_byte;
    do_wr   = 1'b0;
    case (op_e)
      OP_WRITE: begin wr_byte = wdata;          do_wr = 1'b1; end
      OP_SETB:  begin wr_byte = rd_byte | mask;  do_wr = 1'b1; end
      OP_CLRB:  begin wr_byte = rd_byte & ~mask; do_wr = 1'b1; end
      OP_DEC: if (tgt == TGT_REG) begin
        wr_byte = rd_byte - 1'b1;
        do_wr   = 1'b1;
      end
      default: ;
    endcase
  end

  assign ram_we    = core_rst_n && do_wr && (tgt == TGT_RAM);
  assign reg_we    = core_rst_n && do_wr && (tgt == TGT_REG);
  assign rdata     = rd_byte;
  assign bit_flag  = rd_byte[bit_sel];
  assign zero_flag = (op_e == OP_DEC) && (tgt == TGT_REG) && (wr_byte == '0);

  p_upper_fixed_r1: assert property (@(posedge clk) disable iff (!core_rst_n)
    (addr[7:4] == 4'hF) |-> (tgt == TGT_REG));
  p_upper_hole_r1: assert property (@(posedge clk) disable iff (!core_rst_n)
    (addr[7] && addr[6:4] != 3'b111) |-> (rdata == 8'h00));
  p_seg_next_cycle_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (reg_we && reg_idx == 4'hF && !stack_acc) |=> (seg == $past(wr_byte)));
  p_stack_seg0_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (stack_acc && !addr[7] && addr[6:0] < 7'h70) |->
      (tgt == TGT_RAM && ram_idx == RAM_AW'(addr[6:0])));
  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (tgt == TGT_NONE) |-> (rdata == 8'h00 && !bit_flag && !zero_flag));
  p_dec_zero_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
    (op == 3'd4 && addr[7:4] == 4'hF && rdata == 8'h01) |-> zero_flag);
endmodule

// File: tb/test_banked_dmem.sv
`timescale 1ns/1ps
module test_banked_dmem;
  localparam int EXT = 3;
  localparam logic [2:0] RD = 3'd0, WR = 3'd1, SB = 3'd2, CB = 3'd3, DC = 3'd4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] addr, wdata;
  logic [2:0] op, bit_sel;
  logic       stack_acc;
  logic [7:0] rdata;
  logic       bit_flag, zero_flag;

  int nchk = 0, nfail = 0;
  logic [7:0] mdl [int];

  always #10 clk = ~clk;

  banked_dmem #(.EXT_SEGS(EXT)) i_banked_dmem (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .op(op),
    .stack_acc(stack_acc), .bit_sel(bit_sel),
    .rdata(rdata), .bit_flag(bit_flag), .zero_flag(zero_flag)
  );

  function automatic int m_seg();
    return mdl.exists(255) ? int'(mdl[255]) : 0;
  endfunction

  function automatic int phys(logic [7:0] a, bit stk);
    int s = stk ? 0 : m_seg();
    if (a >= 8'hF0) return int'(a);
    if (a >= 8'h80) return -1;
    if (s == 0) return (a < 8'h70) ? int'(a) : -1;
    if (s <= EXT) return s * 256 + int'(a);
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp, input string what);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic acc(input logic [7:0] a, input logic [7:0] wd, input logic [2:0] o,
                     input bit stk, input logic [2:0] bs, input string tag);
    int p;
    bit known;
    logic [7:0] e, m;
    @(negedge clk);
    addr = a; wdata = wd; op = o; stack_acc = stk; bit_sel = bs;
    #1;
    p = phys(a, stk);
    known = 1'b1;
    e = 8'h00;
    if (p >= 0) begin
      if (mdl.exists(p)) e = mdl[p];
      else known = 1'b0;
    end
    if (known) begin
      chk(tag, rdata, e, "rdata");
      chk(tag, {7'd0, bit_flag}, {7'd0, e[bs]}, "bit_flag");
      chk(tag, {7'd0, zero_flag},
          {7'd0, (o == DC && p >= 240 && p <= 255 && e == 8'h01)}, "zero_flag");
    end
    m = 8'h01 << bs;
    if (p >= 0 && !(stk && p == 255)) begin
      case (o)
        WR: mdl[p] = wd;
        SB: if (known) mdl[p] = e | m; else mdl.delete(p);
        CB: if (known) mdl[p] = e & ~m; else mdl.delete(p);
        DC: if (p >= 240 && p <= 255) begin
              if (known) mdl[p] = e - 8'h01; else mdl.delete(p);
            end
        default: ;
      endcase
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    op = RD; stack_acc = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mdl[252] = 8'h00; mdl[253] = 8'h6F; mdl[254] = 8'h00; mdl[255] = 8'h00;
  endtask

  logic [15:0] lfsr;
  bit done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    addr = 8'h00; wdata = 8'h00; op = RD; stack_acc = 1'b0; bit_sel = 3'd0;
    rst_n = 1'b0;
    do_reset();
    // R6 reset values of pointer registers
    acc(8'hFD, 8'h00, RD, 0, 3'd0, "R6");
    acc(8'hFC, 8'h00, RD, 0, 3'd0, "R6");
    acc(8'hFE, 8'h00, RD, 0, 3'd0, "R6");
    acc(8'hFF, 8'h00, RD, 0, 3'd0, "R6");
    for (int i = 240; i < 252; i++) acc(8'(i), 8'(i * 3), WR, 0, 3'd0, "R4");
    // R2 R11 segment 0 RAM and its hole
    acc(8'h00, 8'hA5, WR, 0, 3'd0, "R11");
    acc(8'h6F, 8'h3C, WR, 0, 3'd0, "R2");
    acc(8'h00, 8'h00, RD, 0, 3'd0, "R11");
    acc(8'h6F, 8'h00, RD, 0, 3'd0, "R2");
    acc(8'h70, 8'h77, WR, 0, 3'd0, "R7");
    acc(8'h70, 8'h00, RD, 0, 3'd0, "R2");
    // R1 R7 upper holes
    acc(8'h80, 8'h11, WR, 0, 3'd0, "R1");
    acc(8'hEF, 8'h00, RD, 0, 3'd0, "R1");
    acc(8'h80, 8'h00, RD, 0, 3'd0, "R7");
    // R3 R4 extension segments
    for (int s = 1; s <= EXT + 1; s++) begin
      acc(8'hFF, 8'(s), WR, 0, 3'd0, "R4");
      acc(8'h10, 8'(8'h40 + s), WR, 0, 3'd0, "R3");
      acc(8'h7F, 8'(8'h90 + s), WR, 0, 3'd0, "R3");
    end
    for (int s = 0; s <= EXT + 1; s++) begin
      acc(8'hFF, 8'(s), WR, 0, 3'd0, "R4");
      acc(8'h10, 8'h00, RD, 0, 3'd0, "R3");
      acc(8'h7F, 8'h00, RD, 0, 3'd0, "R3");
      acc(8'hF3, 8'h00, RD, 0, 3'd0, "R1");
    end
    acc(8'hFF, 8'hFF, WR, 0, 3'd0, "R4");
    acc(8'h05, 8'h00, RD, 0, 3'd0, "R7");
    // R5 stack accesses
    acc(8'hFF, 8'h02, WR, 0, 3'd0, "R4");
    acc(8'h20, 8'h5A, WR, 1, 3'd0, "R5");
    acc(8'h20, 8'h00, RD, 1, 3'd0, "R5");
    acc(8'hFF, 8'h07, WR, 1, 3'd0, "R5");
    acc(8'hFF, 8'h00, RD, 0, 3'd0, "R5");
    acc(8'hFF, 8'h00, WR, 0, 3'd0, "R4");
    acc(8'h20, 8'h00, RD, 0, 3'd0, "R5");
    // R10 decrement
    acc(8'hF0, 8'h03, WR, 0, 3'd0, "R10");
    repeat (4) acc(8'hF0, 8'h00, DC, 0, 3'd0, "R10");
    acc(8'hF0, 8'h00, RD, 0, 3'd0, "R10");
    acc(8'h00, 8'h00, DC, 0, 3'd0, "R10");
    acc(8'h00, 8'h00, RD, 0, 3'd0, "R10");
    // R8 R9 bit operations
    acc(8'h30, 8'h00, WR, 0, 3'd0, "R8");
    acc(8'h30, 8'h00, SB, 0, 3'd7, "R8");
    acc(8'h30, 8'h00, SB, 0, 3'd2, "R8");
    acc(8'h30, 8'h00, RD, 0, 3'd7, "R9");
    acc(8'h30, 8'h00, RD, 0, 3'd3, "R9");
    acc(8'h30, 8'h00, CB, 0, 3'd7, "R8");
    acc(8'h30, 8'h00, RD, 0, 3'd7, "R9");
    acc(8'hFE, 8'h00, SB, 0, 3'd4, "R8");
    acc(8'hFE, 8'h00, RD, 0, 3'd4, "R9");
    // R6 RAM survives reset
    do_reset();
    acc(8'h30, 8'h00, RD, 0, 3'd2, "R6");
    acc(8'hFD, 8'h00, RD, 0, 3'd0, "R6");
    // mixed traffic against the model
    lfsr = 16'hACE1;
    for (int n = 0; n < 2000; n++) begin
      logic [7:0] a;
      logic [2:0] o;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr[7:0];
      if (lfsr[8]) a = {lfsr[9], 3'b000, a[3:0]} | (lfsr[10] ? 8'hF0 : 8'h00);
      o = (lfsr[13:11] > 3'd4) ? RD : lfsr[13:11];
      if (a == 8'hFF && o == WR) acc(a, {6'd0, lfsr[15:14]}, o, lfsr[14] & lfsr[15], lfsr[2:0], "R11");
      else acc(a, lfsr[15:8], o, lfsr[14] & lfsr[15], lfsr[2:0], "R11");
    end
    @(negedge clk);
    op = RD;
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule